// File: doc/BRIEF.md
# Tagged Translation Buffer with Flush and Page Invalidate

This block is a small fully associative translation buffer serving one processor. Each entry stores a virtual page number, the 6-bit address-space tag of the process that loaded it, a physical frame number, a writable flag and a modify flag. A lookup presents a virtual address, a read/write indication and the tag of the running process. One cycle later the block answers with a hit and the physical address, a miss, or a protection fault.

On a miss, an external page-table walker is expected to supply a fill. The fill is written together with the current process tag. Because the tag takes part in every comparison, translations of several processes can coexist, and a context switch needs no flush. Two maintenance commands manage entries that have gone stale. A page invalidate removes every entry for one page number, whatever its tag. A flush empties the whole buffer, for use when tags are recycled.

Top module: `xlate_cache`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid and all response outputs are low.
- R2: A lookup hits only when some valid entry holds both the requested page number and the presented tag. A valid entry for the same page under another tag gives a miss.
- R3: The virtual address splits into the page number (upper VPN_W bits) and the offset (lower OFF_W bits). On a hit, `rsp_paddr` equals {frame number, offset}. In every other cycle `rsp_paddr` is zero.
- R4: A fill stores page, frame, writable flag and modify flag together with the `cur_tag` value of that cycle.
- R5: A write lookup that matches an entry whose writable flag is 0 gives `rsp_fault`=1 with `rsp_hit`=0, `rsp_paddr`=0 and `rsp_dirty`=0, and leaves the entry's modify flag unchanged.
- R6: Responses appear on the cycle after the request. Each missing lookup raises `rsp_miss` for exactly that one cycle. With no request, all response flags are low.
- R7: A flush invalidates every entry in one cycle.
- R8: A page invalidate clears every valid entry with that page number, regardless of its tag.
- R9: A fill whose page and current tag are already present overwrites that entry in place and does not move the replacement pointer. Any other fill goes to the entry at a round-robin pointer, which then advances by one and wraps after the last entry (8 by default). Flush does not move the pointer.
- R10: A write hit on a writable entry sets its modify flag. On any hit, `rsp_dirty` reports the modify flag as it stands after that access.
- R11: At most one maintenance action takes effect per cycle, with flush over invalidate over fill; a fill that loses is dropped. A lookup sees the contents from before that cycle's maintenance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Lookup is a write |
| req_vaddr | input | VPN_W+OFF_W | Virtual address of the lookup |
| cur_tag | input | TAG_W | Tag of the running process, used by lookups and fills |
| fill_valid | input | 1 | Load a translation |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_writable | input | 1 | Fill allows writes |
| fill_dirty | input | 1 | Initial modify flag of the fill |
| inv_valid | input | 1 | Invalidate by page |
| inv_vpn | input | VPN_W | Page number to invalidate |
| flush | input | 1 | Invalidate all entries |
| rsp_hit | output | 1 | Lookup of previous cycle hit |
| rsp_miss | output | 1 | Lookup of previous cycle missed |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_dirty | output | 1 | Modify flag of the hit entry |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on a hit, else zero |

## Verification
The bench goes after translations that are alike except for their tag. A design that ignored the tag would hit across processes, and one that honoured the tag during invalidate would leave a stale mapping alive under the other tag. It loads more pages than there are entries and reloads a page that is already present. A faulty pointer would then evict the wrong page, and a design without the in-place overwrite would hold duplicate entries. Same-cycle collisions of lookup, fill, invalidate and flush are also driven, so a wrong priority or a lookup that sees new contents too early shows up as a wrong hit or miss. Writes to read-only pages must fault without setting the modify flag.

// File: rtl/xc_pkg.sv
// Package: shared types of the tagged translation buffer.
// Assumes: nothing; holds only the maintenance action encoding.
package xc_pkg;
    typedef enum logic [1:0] {
        MNT_NONE  = 2'd0,
        MNT_FLUSH = 2'd1,
        MNT_INV   = 2'd2,
        MNT_FILL  = 2'd3
    } mnt_e;
endpackage

// File: rtl/xc_match.sv
// Module: xc_match
// Compares every entry against three keys: the lookup (page and tag), the
// fill (page and current tag) and the invalidate (page only).
// Assumes: at most one valid entry per page/tag pair, kept so by the fill path.
module xc_match #(
    parameter int VPN_W   = 20,
    parameter int TAG_W   = 6,
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_q,
    input  logic [VPN_W-1:0]   vpn_q [ENTRIES],
    input  logic [TAG_W-1:0]   tag_q [ENTRIES],
    input  logic [VPN_W-1:0]   look_vpn,
    input  logic [TAG_W-1:0]   look_tag,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [VPN_W-1:0]   inv_vpn,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [ENTRIES-1:0] fill_vec,
    output logic [ENTRIES-1:0] inv_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // Per-entry comparators for the three keys.
        always_comb begin
            hit_vec[g]  = valid_q[g] && (vpn_q[g] == look_vpn) && (tag_q[g] == look_tag);
            fill_vec[g] = valid_q[g] && (vpn_q[g] == fill_vpn) && (tag_q[g] == look_tag);
            inv_vec[g]  = valid_q[g] && (vpn_q[g] == inv_vpn);
        end
    end

    AST_LOOKUP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R9
endmodule

// File: rtl/xc_victim.sv
// Module: xc_victim
// Round-robin replacement pointer; moves by one on each allocating fill.
// Assumes: advance is asserted only for fills that take a new entry.
module xc_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Pointer register with wrap after the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1))); // R9
    AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr)); // R9
endmodule

// File: rtl/xlate_cache.sv
// Module: xlate_cache (top)
// Fully associative translation buffer with per-process tags. It answers
// lookups one cycle after the request and takes fills, page invalidates
// and flushes.
// Assumes: one maintenance action per cycle is applied (flush > invalidate
// > fill); a lookup sees the state from before that cycle's update.
module xlate_cache #(
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int PFN_W   = 20,
    parameter int TAG_W   = 6,
    parameter int ENTRIES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
    input  logic [TAG_W-1:0]         cur_tag,
    input  logic                     fill_valid,
    input  logic [VPN_W-1:0]         fill_vpn,
    input  logic [PFN_W-1:0]         fill_pfn,
    input  logic                     fill_writable,
    input  logic                     fill_dirty,
    input  logic                     inv_valid,
    input  logic [VPN_W-1:0]         inv_vpn,
    input  logic                     flush,
    output logic                     rsp_hit,
    output logic                     rsp_miss,
    output logic                     rsp_fault,
    output logic                     rsp_dirty,
    output logic [PFN_W+OFF_W-1:0]   rsp_paddr
);
    import xc_pkg::*;

    localparam int VA_W  = VPN_W + OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q, wr_q, mod_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];

    logic [VPN_W-1:0]   look_vpn;
    logic [OFF_W-1:0]   look_off;
    logic [ENTRIES-1:0] hit_vec, fill_vec, inv_vec;
    logic [IDX_W-1:0]   ptr, hit_idx, fill_idx, tgt_idx;
    logic [PFN_W-1:0]   sel_pfn;
    logic               sel_wr, sel_mod, any_hit, fill_hit;
    logic               fault_c, ok_hit_c, adv;
    mnt_e               act;

    // Split the virtual address into page and offset.
    always_comb begin
        look_vpn = req_vaddr[VA_W-1:OFF_W];
        look_off = req_vaddr[OFF_W-1:0];
    end

    xc_match #(.VPN_W(VPN_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_q  (valid_q),
        .vpn_q    (vpn_q),
        .tag_q    (tag_q),
        .look_vpn (look_vpn),
        .look_tag (cur_tag),
        .fill_vpn (fill_vpn),
        .inv_vpn  (inv_vpn),
        .hit_vec  (hit_vec),
        .fill_vec (fill_vec),
        .inv_vec  (inv_vec)
    );

    // Gather the hit entry's fields and the fill target's index.
    always_comb begin
        sel_pfn  = '0;
        sel_wr   = 1'b0;
        sel_mod  = 1'b0;
        hit_idx  = '0;
        fill_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                sel_pfn = sel_pfn | pfn_q[i];
                sel_wr  = sel_wr  | wr_q[i];
                sel_mod = sel_mod | mod_q[i];
                hit_idx = hit_idx | IDX_W'(i);
            end
            if (fill_vec[i]) begin
                fill_idx = fill_idx | IDX_W'(i);
            end
        end
        any_hit  = |hit_vec;
        fill_hit = |fill_vec;
        fault_c  = req_valid && any_hit && req_write && !sel_wr;
        ok_hit_c = req_valid && any_hit && !fault_c;
    end

    // Pick the single maintenance action of this cycle and the fill target.
    always_comb begin
        if (flush)           act = MNT_FLUSH;
        else if (inv_valid)  act = MNT_INV;
        else if (fill_valid) act = MNT_FILL;
        else                 act = MNT_NONE;
        tgt_idx = fill_hit ? fill_idx : ptr;
        adv     = (act == MNT_FILL) && !fill_hit;
    end

    xc_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (adv),
        .ptr     (ptr)
    );

    // Registered lookup response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_dirty <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_hit   <= ok_hit_c;
            rsp_miss  <= req_valid && !any_hit;
            rsp_fault <= fault_c;
            rsp_dirty <= ok_hit_c && (sel_mod || req_write);
            rsp_paddr <= ok_hit_c ? {sel_pfn, look_off} : '0;
        end
    end

    // Entry storage: modify-flag update, then maintenance (which overrides).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            wr_q    <= '0;
            mod_q   <= '0;
        end else begin
            if (ok_hit_c && req_write) begin
                mod_q[hit_idx] <= 1'b1;
            end
            case (act)
                MNT_FLUSH: valid_q <= '0;
                MNT_INV:   valid_q <= valid_q & ~inv_vec;
                MNT_FILL: begin
                    valid_q[tgt_idx] <= 1'b1;
                    vpn_q[tgt_idx]   <= fill_vpn;
                    tag_q[tgt_idx]   <= cur_tag;
                    pfn_q[tgt_idx]   <= fill_pfn;
                    wr_q[tgt_idx]    <= fill_writable;
                    mod_q[tgt_idx]   <= fill_dirty;
                end
                default: ;
            endcase
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R7
    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !flush) |=> ((valid_q & $past(inv_vec)) == '0)); // R8
    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_miss || rsp_fault) |-> $past(req_valid)); // R6
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (!rsp_hit && !rsp_dirty && rsp_paddr == '0)); // R5
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_hit, rsp_miss, rsp_fault}) <= 1); // R6
endmodule

// File: tb/xlate_cache_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge, compared
// with the design's outputs on each falling edge.
module xlate_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [31:0] req_vaddr;
    logic [5:0]  cur_tag;
    logic        fill_valid, fill_writable, fill_dirty;
    logic [19:0] fill_vpn, fill_pfn, inv_vpn;
    logic        inv_valid, flush;
    logic        rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
    logic [31:0] rsp_paddr;

    always #4 clk = ~clk;

    xlate_cache u_xlate_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_vaddr(req_vaddr), .cur_tag(cur_tag), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_writable(fill_writable),
        .fill_dirty(fill_dirty), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .flush(flush), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty), .rsp_paddr(rsp_paddr)
    );

    // Reference model state
    bit          m_v [8];
    bit          m_w [8];
    bit          m_d [8];
    logic [19:0] m_vpn [8];
    logic [5:0]  m_tag [8];
    logic [19:0] m_pfn [8];
    int          m_rr;
    bit          e_hit, e_miss, e_fault, e_dirty, started;
    logic [31:0] e_pa;
    int          n_chk = 0, n_fail = 0;
    string       cur_req = "R1";

    // Model: respond from the old state, then apply modify flag and maintenance.
    always @(posedge clk) begin
        int idx, f;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_v[i] = 0;
            m_rr = 0;
            {e_hit, e_miss, e_fault, e_dirty} = 4'b0;
            e_pa = 0;
        end else begin
            idx = -1;
            {e_hit, e_miss, e_fault, e_dirty} = 4'b0;
            e_pa = 0;
            if (req_valid) begin
                for (int i = 0; i < 8; i++)
                    if (m_v[i] && m_vpn[i] == req_vaddr[31:12] && m_tag[i] == cur_tag) idx = i;
                if (idx < 0) e_miss = 1;
                else if (req_write && !m_w[idx]) e_fault = 1;
                else begin
                    e_hit   = 1;
                    e_pa    = {m_pfn[idx], req_vaddr[11:0]};
                    e_dirty = m_d[idx] | req_write;
                    if (req_write) m_d[idx] = 1;
                end
            end
            if (flush) begin
                for (int i = 0; i < 8; i++) m_v[i] = 0;
            end else if (inv_valid) begin
                for (int i = 0; i < 8; i++) if (m_vpn[i] == inv_vpn) m_v[i] = 0;
            end else if (fill_valid) begin
                f = -1;
                for (int i = 0; i < 8; i++)
                    if (m_v[i] && m_vpn[i] == fill_vpn && m_tag[i] == cur_tag) f = i;
                if (f < 0) begin
                    f = m_rr;
                    m_rr = (m_rr + 1) % 8;
                end
                m_v[f] = 1; m_vpn[f] = fill_vpn; m_tag[f] = cur_tag;
                m_pfn[f] = fill_pfn; m_w[f] = fill_writable; m_d[f] = fill_dirty;
            end
        end
        started = 1;
    end

    task automatic compare();
        if (started) begin
            n_chk++;
            if ({rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_paddr} !==
                {e_hit, e_miss, e_fault, e_dirty, e_pa}) begin
                n_fail++;
                $display("FAIL %s: hit/miss/fault/dirty/paddr actual %b%b%b%b %h expected %b%b%b%b %h",
                         cur_req, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_paddr,
                         e_hit, e_miss, e_fault, e_dirty, e_pa);
            end
        end
    endtask

    // Start of every cycle: check last edge's response, clear all inputs.
    task automatic next_cycle();
        @(negedge clk);
        compare();
        req_valid = 0; req_write = 0; fill_valid = 0; inv_valid = 0; flush = 0;
    endtask

    task automatic idle();
        next_cycle();
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [5:0] tag, input bit wr);
        next_cycle();
        req_valid = 1; req_write = wr; req_vaddr = {vpn, off}; cur_tag = tag;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [5:0] tag, input bit w, input bit d);
        next_cycle();
        fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; cur_tag = tag;
        fill_writable = w; fill_dirty = d;
    endtask

    task automatic run_tests();
        rst_n = 0; req_valid = 0; req_write = 0; req_vaddr = 0; cur_tag = 0;
        fill_valid = 0; fill_vpn = 0; fill_pfn = 0; fill_writable = 0;
        fill_dirty = 0; inv_valid = 0; inv_vpn = 0; flush = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state, empty buffer misses
        cur_req = "R1"; idle(); look(20'h00001, 12'h000, 6'd5, 0); idle();
        // R4: fills carry the current tag
        cur_req = "R4";
        fill(20'h00001, 20'hA0001, 6'd5, 1, 0);
        fill(20'h00002, 20'hA0002, 6'd5, 0, 0);
        fill(20'h00003, 20'hA0003, 6'd7, 1, 1);
        look(20'h00001, 12'h123, 6'd5, 0); look(20'h00003, 12'h001, 6'd5, 0);
        look(20'h00003, 12'h001, 6'd7, 0);
        // R2: same page, other tag misses
        cur_req = "R2";
        look(20'h00002, 12'h000, 6'd6, 0); look(20'h00009, 12'h000, 6'd5, 0);
        // R3: physical address formation across offsets
        cur_req = "R3";
        look(20'h00001, 12'hFFF, 6'd5, 0); look(20'h00002, 12'h800, 6'd5, 0);
        look(20'h00003, 12'h000, 6'd7, 0);
        // R5: write to read-only page faults, modify flag stays clear
        cur_req = "R5";
        look(20'h00002, 12'h010, 6'd5, 1); look(20'h00002, 12'h010, 6'd5, 0);
        // R10: write hit sets modify flag
        cur_req = "R10";
        look(20'h00001, 12'h004, 6'd5, 1); look(20'h00001, 12'h004, 6'd5, 0);
        look(20'h00003, 12'h004, 6'd7, 0);
        // R6: back-to-back misses, then silence
        cur_req = "R6";
        look(20'h00100, 12'h0, 6'd5, 0); look(20'h00101, 12'h0, 6'd5, 0);
        idle(); idle();
        // R9: overflow the buffer and refill an existing page in place
        cur_req = "R9";
        for (int k = 0; k < 9; k++) fill(20'h00200 + k, 20'hB0000 + k, 6'd9, 1, 0);
        fill(20'h00205, 20'hC0005, 6'd9, 0, 1);
        fill(20'h00300, 20'hC0300, 6'd9, 1, 0);
        for (int k = 0; k < 9; k++) look(20'h00200 + k, 12'h021, 6'd9, 0);
        look(20'h00300, 12'h0, 6'd9, 0); look(20'h00001, 12'h0, 6'd5, 0);
        // R8: invalidate by page clears both tags
        cur_req = "R8";
        fill(20'h00400, 20'hD0000, 6'd1, 1, 0);
        fill(20'h00400, 20'hD0001, 6'd2, 1, 0);
        look(20'h00400, 12'h0, 6'd1, 0); look(20'h00400, 12'h0, 6'd2, 0);
        next_cycle(); inv_valid = 1; inv_vpn = 20'h00400;
        look(20'h00400, 12'h0, 6'd1, 0); look(20'h00400, 12'h0, 6'd2, 0);
        look(20'h00208, 12'h0, 6'd9, 0);
        // R7: flush empties everything
        cur_req = "R7";
        next_cycle(); flush = 1;
        look(20'h00208, 12'h0, 6'd9, 0); look(20'h00300, 12'h0, 6'd9, 0);
        // R11: lookup with same-cycle fill sees old state; priorities
        cur_req = "R11";
        next_cycle();
        req_valid = 1; req_vaddr = {20'h00500, 12'h055}; cur_tag = 6'd3;
        fill_valid = 1; fill_vpn = 20'h00500; fill_pfn = 20'hE0500;
        fill_writable = 1; fill_dirty = 0;
        look(20'h00500, 12'h055, 6'd3, 0);
        next_cycle(); flush = 1; fill_valid = 1; fill_vpn = 20'h00600;
        fill_pfn = 20'hE0600; cur_tag = 6'd3;
        look(20'h00600, 12'h0, 6'd3, 0); look(20'h00500, 12'h0, 6'd3, 0);
        fill(20'h00700, 20'hE0700, 6'd3, 1, 0);
        next_cycle(); inv_valid = 1; inv_vpn = 20'h00700; fill_valid = 1;
        fill_vpn = 20'h00800; fill_pfn = 20'hE0800; cur_tag = 6'd3;
        look(20'h00800, 12'h0, 6'd3, 0); look(20'h00700, 12'h0, 6'd3, 0);
        // R1: reset mid-run empties the buffer
        cur_req = "R1";
        fill(20'h00900, 20'hF0900, 6'd4, 1, 0);
        next_cycle(); rst_n = 0;
        next_cycle(); rst_n = 1;
        look(20'h00900, 12'h0, 6'd4, 0);
        idle(); idle();
    endtask

    initial begin
        bit timed_out = 0;
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule